// File: doc/BRIEF.md
# Addressed Discrete I/O Bank with Halt Flag

This block holds sixteen single-bit output latches for a small 4-bit controller core. An address register value selects one latch. A set strobe, a clear strobe or a sense strobe then acts on that latch alone. The lower fourteen bits always face a pad. Each of those pads is open-drain: a latch at 1 releases the pad, and a latch at 0 pulls it low. A sense operation returns the latch ANDed with the pad level. To read an external level, software must first leave the latch released.

The top two bits take one of three forms, chosen by a parameter. In the first form they are ordinary pad bits. In the second they are internal register bits, and the highest one also acts as the run flag. In the third they are internal register bits with no halt function. In the run-flag form, clearing the top bit puts the core into internal halt. A pulse from a free-running prescaler's overflow sets the bit again and wakes the core.

Top module: `dio_bank`

## Requirements
- R1: During and after reset, every latch holds 1, every bit of `pad_oe` is 0, `cpu_halt` is 0 and `test_bit` is 0.
- R2: A set or clear strobe changes only the latch whose index equals `y_addr`, and the change is visible on the next clock edge. For a pad bit, `pad_oe[i]` is 1 exactly when latch i holds 0.
- R3: When set and clear strobes arrive in the same cycle, set wins and the addressed latch ends at 1.
- R4: One edge after a sense strobe, `test_bit` equals the addressed latch AND `pad_in` at that address, both taken at the strobe edge. Without a strobe, `test_bit` holds its value.
- R5: In the two register forms (`UPPER_MODE` 1 or 2), `pad_oe[15:14]` stays 0 and `pad_in[15:14]` has no effect. A sense on address 14 or 15 returns the register bit.
- R6: In the run-flag form (`UPPER_MODE` = 1), `cpu_halt` is the inverse of latch 15. A clear of address 15 raises `cpu_halt` on the next edge.
- R7: In the run-flag form, a `tick_ovf` pulse sets latch 15 and drops `cpu_halt`. This holds even when a clear of address 15 arrives in the same cycle.
- R8: In the other two forms (`UPPER_MODE` 0 or 2), `cpu_halt` stays 0 and `tick_ovf` has no effect on any latch.
- R9: In the pad form (`UPPER_MODE` = 0), bits 14 and 15 behave exactly like bits 0 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| y_addr | input | 4 | Latch index used by every strobe |
| set_stb | input | 1 | Set the addressed latch to 1 |
| clr_stb | input | 1 | Clear the addressed latch to 0 |
| test_stb | input | 1 | Capture the wired sense of the addressed bit |
| tick_ovf | input | 1 | Prescaler overflow pulse (wake source) |
| pad_in | input | 16 | Pad levels as seen at the pins |
| pad_oe | output | 16 | Pull-low enable per pad (1 = drive 0) |
| test_bit | output | 1 | Registered result of the last sense |
| cpu_halt | output | 1 | Core halt request |

## Verification
On every cycle, the bound checker confirms several relations at the ports. Outputs stay stable when no strobe is present. Set wins over clear. Each sensed value matches the released state of the pad ANDed with its level. The upper pads stay quiet in register forms, and the halt output follows the clear and wake events in each form. Some behaviours only the bench's scenarios can show. These are that each address reaches only its own latch, that register bits hold their values without a pad to observe, and that a wake pulse has no effect in the forms without halt. The bench drives one stimulus stream into all three forms at once for this.

// File: rtl/dio_pkg.sv
package dio_pkg;

    // Personality of the two highest latches
    typedef enum logic [1:0] {
        UPPER_PINS      = 2'd0,
        UPPER_REG_HALT  = 2'd1,
        UPPER_REG_PLAIN = 2'd2
    } upper_mode_e;

    // Strobes that reach a single latch cell
    typedef struct packed {
        logic set;
        logic clr;
    } dio_cmd_t;

    // True when bit idx faces a pad under the chosen personality
    function automatic bit is_pad_bit(int idx, int nbits, upper_mode_e mode);
        return (idx < nbits - 2) || (mode == UPPER_PINS);
    endfunction

    // True when bit idx is the run flag woken by prescaler overflow
    function automatic bit is_wake_bit(int idx, int nbits, upper_mode_e mode);
        return (idx == nbits - 1) && (mode == UPPER_REG_HALT);
    endfunction

endpackage

// File: rtl/dio_addr_decode.sv
module dio_addr_decode #(
    parameter int N_BITS = 16,
    localparam int AW    = $clog2(N_BITS)
) (
    input  logic [AW-1:0]     addr,
    output logic [N_BITS-1:0] sel
);
    for (genvar i = 0; i < N_BITS; i++) begin : g_dec
        assign sel[i] = (addr == AW'(i));
    end
endmodule

// File: rtl/dio_bit_cell.sv
module dio_bit_cell
    import dio_pkg::*;
#(
    parameter bit PAD_BIT  = 1'b1,
    parameter bit WAKE_BIT = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sel,
    input  dio_cmd_t cmd,
    input  logic     wake,
    input  logic     pad_lvl,
    output logic     latch_q,
    output logic     oe,
    output logic     sense
);
    logic do_set;
    logic do_clr;
    logic pad_eff;

    // set (or wake on the run flag) beats clear
    assign do_set = (sel && cmd.set) || (WAKE_BIT && wake);
    assign do_clr = sel && cmd.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b1;
        end else if (do_set) begin
            latch_q <= 1'b1;
        end else if (do_clr) begin
            latch_q <= 1'b0;
        end
    end

    // open-drain: a 0 in the latch pulls the pad low
    assign pad_eff = PAD_BIT ? pad_lvl : 1'b1;
    assign oe      = PAD_BIT ? ~latch_q : 1'b0;
    assign sense   = latch_q & pad_eff;
endmodule

// File: rtl/dio_sense_reg.sv
module dio_sense_reg #(
    parameter int N_BITS = 16,
    localparam int AW    = $clog2(N_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [AW-1:0]     addr,
    input  logic [N_BITS-1:0] sense,
    output logic              result
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= 1'b0;
        end else if (strobe) begin
            result <= sense[addr];
        end
    end
endmodule

// File: rtl/dio_bank.sv
module dio_bank
    import dio_pkg::*;
#(
    parameter int          N_BITS     = 16,
    parameter upper_mode_e UPPER_MODE = UPPER_REG_HALT,
    localparam int         AW         = $clog2(N_BITS),
    localparam int         FLAG_IDX   = N_BITS - 1,
    localparam bit         HALT_EN    = (UPPER_MODE == UPPER_REG_HALT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     y_addr,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic              test_stb,
    input  logic              tick_ovf,
    input  logic [N_BITS-1:0] pad_in,
    output logic [N_BITS-1:0] pad_oe,
    output logic              test_bit,
    output logic              cpu_halt
);
    logic [N_BITS-1:0] sel;
    logic [N_BITS-1:0] latch_v;
    logic [N_BITS-1:0] sense_v;
    dio_cmd_t          cmd;

    assign cmd.set = set_stb;
    assign cmd.clr = clr_stb;

    dio_addr_decode #(.N_BITS(N_BITS)) u_dec (
        .addr (y_addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < N_BITS; i++) begin : g_cell
        dio_bit_cell #(
            .PAD_BIT  (is_pad_bit(i, N_BITS, UPPER_MODE)),
            .WAKE_BIT (is_wake_bit(i, N_BITS, UPPER_MODE))
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel[i]),
            .cmd     (cmd),
            .wake    (tick_ovf),
            .pad_lvl (pad_in[i]),
            .latch_q (latch_v[i]),
            .oe      (pad_oe[i]),
            .sense   (sense_v[i])
        );
    end

    dio_sense_reg #(.N_BITS(N_BITS)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .strobe (test_stb),
        .addr   (y_addr),
        .sense  (sense_v),
        .result (test_bit)
    );

    if (HALT_EN) begin : g_halt
        assign cpu_halt = ~latch_v[FLAG_IDX];
    end else begin : g_nohalt
        assign cpu_halt = 1'b0;
    end
endmodule

// File: rtl/dio_bank_checker.sv
module dio_bank_checker
    import dio_pkg::*;
#(
    parameter int          N_BITS     = 16,
    parameter upper_mode_e UPPER_MODE = UPPER_REG_HALT,
    localparam int         AW         = $clog2(N_BITS)
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     y_addr,
    input logic              set_stb,
    input logic              clr_stb,
    input logic              test_stb,
    input logic              tick_ovf,
    input logic [N_BITS-1:0] pad_in,
    input logic [N_BITS-1:0] pad_oe,
    input logic              test_bit,
    input logic              cpu_halt
);
    localparam logic [AW-1:0] PAD_LIM = AW'(N_BITS - 2);
    localparam logic [AW-1:0] TOP     = AW'(N_BITS - 1);

    logic pad_addr;
    assign pad_addr = (y_addr < PAD_LIM) || (UPPER_MODE == UPPER_PINS);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && !cpu_halt && !test_bit);

    // R2
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(pad_oe));

    // R3
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_stb && clr_stb) |=> !pad_oe[$past(y_addr)]);

    // R4
    a_r4_wired_sense: assert property (@(posedge clk) disable iff (rst)
        (test_stb && pad_addr) |=>
            test_bit == $past(!pad_oe[y_addr] && pad_in[y_addr]));

    a_r4_sense_hold: assert property (@(posedge clk) disable iff (rst)
        !test_stb |=> $stable(test_bit));

    if (UPPER_MODE != UPPER_PINS) begin : g_reg
        // R5
        a_r5_upper_quiet: assert property (@(posedge clk) disable iff (rst)
            pad_oe[N_BITS-1:N_BITS-2] == 2'b00);
    end

    if (UPPER_MODE == UPPER_REG_HALT) begin : g_halt
        // R6
        a_r6_halt_entry: assert property (@(posedge clk) disable iff (rst)
            (clr_stb && !set_stb && !tick_ovf && y_addr == TOP) |=> cpu_halt);
        // R7
        a_r7_wake: assert property (@(posedge clk) disable iff (rst)
            tick_ovf |=> !cpu_halt);
    end else begin : g_nohalt
        // R8
        a_r8_no_halt: assert property (@(posedge clk) disable iff (rst)
            !cpu_halt);
    end
endmodule

bind dio_bank dio_bank_checker #(
    .N_BITS     (N_BITS),
    .UPPER_MODE (UPPER_MODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .y_addr   (y_addr),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb),
    .test_stb (test_stb),
    .tick_ovf (tick_ovf),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .test_bit (test_bit),
    .cpu_halt (cpu_halt)
);

// File: tb/dio_bank_test.sv
`timescale 1ns/1ps
module dio_bank_test;
    import dio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  y_addr = '0;
    logic        set_stb = 1'b0, clr_stb = 1'b0, test_stb = 1'b0, tick_ovf = 1'b0;
    logic [15:0] pad_in = '1;

    logic [15:0] oe_h, oe_p, oe_r;
    logic        tb_h, tb_p, tb_r;
    logic        hl_h, hl_p, hl_r;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dio_bank #(.UPPER_MODE(UPPER_REG_HALT)) uut (
        .clk(clk), .rst(rst), .y_addr(y_addr), .set_stb(set_stb), .clr_stb(clr_stb),
        .test_stb(test_stb), .tick_ovf(tick_ovf), .pad_in(pad_in),
        .pad_oe(oe_h), .test_bit(tb_h), .cpu_halt(hl_h));

    dio_bank #(.UPPER_MODE(UPPER_PINS)) uut_pins (
        .clk(clk), .rst(rst), .y_addr(y_addr), .set_stb(set_stb), .clr_stb(clr_stb),
        .test_stb(test_stb), .tick_ovf(tick_ovf), .pad_in(pad_in),
        .pad_oe(oe_p), .test_bit(tb_p), .cpu_halt(hl_p));

    dio_bank #(.UPPER_MODE(UPPER_REG_PLAIN)) uut_plain (
        .clk(clk), .rst(rst), .y_addr(y_addr), .set_stb(set_stb), .clr_stb(clr_stb),
        .test_stb(test_stb), .tick_ovf(tick_ovf), .pad_in(pad_in),
        .pad_oe(oe_r), .test_bit(tb_r), .cpu_halt(hl_r));

    // op codes: 0 set, 1 clear, 2 sense, 3 tick, 4 set+clear
    // entry = {op[2:0], addr[3:0], pad level, expected}
    // expected is pad_oe[addr] of the pad-form unit, or its test_bit for op 2
    localparam int NV = 15;
    localparam logic [8:0] VEC [NV] = '{
        {3'd1, 4'd3,  1'b1, 1'b1},
        {3'd2, 4'd3,  1'b1, 1'b0},
        {3'd0, 4'd3,  1'b1, 1'b0},
        {3'd2, 4'd3,  1'b1, 1'b1},
        {3'd2, 4'd3,  1'b0, 1'b0},
        {3'd4, 4'd5,  1'b1, 1'b0},
        {3'd1, 4'd15, 1'b1, 1'b1},
        {3'd2, 4'd15, 1'b1, 1'b0},
        {3'd3, 4'd15, 1'b1, 1'b1},
        {3'd0, 4'd15, 1'b1, 1'b0},
        {3'd1, 4'd0,  1'b1, 1'b1},
        {3'd2, 4'd0,  1'b1, 1'b0},
        {3'd0, 4'd0,  1'b1, 1'b0},
        {3'd1, 4'd14, 1'b1, 1'b1},
        {3'd0, 4'd14, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one strobe cycle; results are sampled at the following falling edge
    task automatic op(input logic [2:0] code, input logic [3:0] a, input logic lvl);
        @(negedge clk);
        y_addr   = a;
        pad_in   = {16{lvl}};
        set_stb  = (code == 3'd0) || (code == 3'd4);
        clr_stb  = (code == 3'd1) || (code == 3'd4);
        test_stb = (code == 3'd2);
        tick_ovf = (code == 3'd3);
        @(negedge clk);
        set_stb = 1'b0; clr_stb = 1'b0; test_stb = 1'b0; tick_ovf = 1'b0;
    endtask

    task automatic op_raw(input logic s, input logic c, input logic t, input logic [3:0] a);
        @(negedge clk);
        y_addr = a; set_stb = s; clr_stb = c; tick_ovf = t;
        @(negedge clk);
        set_stb = 1'b0; clr_stb = 1'b0; tick_ovf = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state held during reset
        chk("R1 oe in reset", oe_h | oe_p | oe_r, 0);
        chk("R1 halt in reset", {hl_h, hl_p, hl_r}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", oe_p, 0);
        chk("R1 test_bit after reset", {tb_h, tb_p, tb_r}, 0);

        // table walk on the pad-form unit (R2 R3 R4 R9)
        for (int k = 0; k < NV; k++) begin
            op(VEC[k][8:6], VEC[k][5:2], VEC[k][1]);
            if (VEC[k][8:6] == 3'd2)
                chk("R4 table sense", tb_p, VEC[k][0]);
            else if (VEC[k][8:6] == 3'd4)
                chk("R3 table set wins", oe_p[VEC[k][5:2]], VEC[k][0]);
            else if (VEC[k][5:2] >= 4'd14)
                chk("R9 table upper pad", oe_p[VEC[k][5:2]], VEC[k][0]);
            else
                chk("R2 table latch", oe_p[VEC[k][5:2]], VEC[k][0]);
        end

        // R2 R4 every address touches only its own latch
        for (int a = 0; a < 16; a++) begin
            op(3'd1, 4'(a), 1'b1);
            chk("R2 clear isolates", oe_p, 16'(1) << a);
            op(3'd2, 4'(a), 1'b1);
            chk("R4 sense low latch", tb_p, 0);
            op(3'd0, 4'(a), 1'b1);
            chk("R2 set releases", oe_p, 0);
            op(3'd2, 4'(a), 1'b1);
            chk("R4 sense released high pad", tb_p, 1);
        end

        // R4 released latch reads the external low level
        op(3'd2, 4'd7, 1'b0);
        chk("R4 sense external low", tb_p, 0);

        // R5 register forms ignore pads on bits 14 and 15
        op(3'd1, 4'd14, 1'b1);
        chk("R5 upper oe quiet", {oe_h[15:14], oe_r[15:14]}, 0);
        op(3'd2, 4'd14, 1'b1);
        chk("R5 cleared reg ignores high pad", {tb_h, tb_r}, 2'b00);
        op(3'd0, 4'd14, 1'b0);
        op(3'd2, 4'd14, 1'b0);
        chk("R5 set reg ignores low pad", {tb_h, tb_r}, 2'b11);
        chk("R9 pad form reads low pad", tb_p, 0);

        // R6 halt entry
        op(3'd1, 4'd15, 1'b1);
        chk("R6 halt entered", hl_h, 1);
        chk("R8 other forms not halted", {hl_p, hl_r}, 0);
        op(3'd2, 4'd15, 1'b1);
        chk("R6 flag reads zero", tb_h, 0);

        // R7 wake by overflow
        op(3'd3, 4'd0, 1'b1);
        chk("R7 wake on tick", hl_h, 0);
        // R8 tick leaves the plain-register flag and pad latch cleared
        op(3'd2, 4'd15, 1'b1);
        chk("R8 plain flag unchanged by tick", tb_r, 0);
        chk("R8 pad form unchanged by tick", oe_p[15], 1);
        chk("R7 flag set by tick", tb_h, 1);

        // R7 wake beats clear in the same cycle
        op_raw(1'b0, 1'b1, 1'b1, 4'd15);
        chk("R7 tick beats clear", hl_h, 0);
        chk("R8 plain still no halt", hl_r, 0);

        // R1 reset again from a disturbed state
        op(3'd1, 4'd15, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 reset releases all", {oe_p, 1'b0}, 0);
        chk("R1 reset clears halt", hl_h, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule